// File: doc/BRIEF.md
# System-to-Peripheral Bus Bridge

This block joins a fast, request-driven system bus to a slow two-phase peripheral bus. A system master places one transfer on the request interface and holds it there. The bridge moves it onto the peripheral bus as a setup phase followed by an access phase. The peripheral side runs on a strobe derived from the system clock, and its rate is picked at run time from five powers of two. Every peripheral transfer is a full 32-bit word. Narrow writes from the system side are widened by copying the active byte or halfword into every lane. Reads come back unchanged.

Peripherals sit in 64 slots of 1 KB each, and address bits [15:10] select the slot. Upper address bits are resolved by the interconnect before the bridge and do not reach it. A per-slot clock-enable mask decides which slots may be selected. A transfer aimed at a slot whose enable is off finishes at once without touching the peripheral bus, and a read from such a slot returns zero.

The request side follows valid/ready rules. The master raises `sys_valid` with the command fields and keeps all of them stable until it sees `sys_ready` high for one cycle. That pulse marks completion and carries the read data. The bridge takes one request at a time. Back-pressure lasts for the whole peripheral transfer, including wait states added by the peripheral through `p_ready`.

Top module: `periph_bridge`

## Requirements
- R1: `p_tick` is the peripheral clock strobe. A free-running counter starts at 0 on reset and advances once per system cycle. `p_tick` is high whenever the low `div_sel` bits of that counter are all ones. The divisor is 1, 2, 4, 8 or 16 for `div_sel` = 0, 1, 2, 3 or 4, and any `div_sel` of 4 or more gives 16.
- R2: A request that is waiting in idle is accepted only on a cycle with `p_tick` high. From the next cycle, the setup phase drives `p_sel` with `p_enable` low. The access phase starts on the cycle after the next `p_tick`.
- R3: The access phase keeps `p_sel` and `p_enable` high until a cycle where both `p_tick` and `p_ready` are high. Cycles with `p_ready` low add wait states.
- R4: `sys_ready` goes high for exactly one cycle, on the cycle after the transfer ends. The bridge then returns to idle.
- R5: A read from an enabled slot returns the `p_rdata` value that was present when the access phase completed. A write returns zero.
- R6: `sys_size` 00 is a byte, 01 is a halfword, and 10 or 11 is a word. Lanes are little-endian: byte n is bits [8n+7:8n]. A byte write copies the byte at lane `sys_addr[1:0]` into all four lanes. A halfword write copies the halfword at lane `sys_addr[1]` into both halves. A word write passes through unchanged.
- R7: `p_sel` is one-hot on bit `sys_addr[15:10]` during setup and access, and zero at all other times. `p_addr` is `sys_addr[15:2]` with bits [1:0] forced to zero.
- R8: After reset, the enable mask equals parameter `KEEP_ON` (default: slots 0 and 1, the memory interfaces). A cycle with `en_we` high loads the whole mask from `en_wdata`.
- R9: A request to a slot whose enable is clear is accepted on a `p_tick`. It then completes with `sys_ready` on the next cycle and `sys_rdata` = 0, and raises no `p_sel` or `p_enable`.
- R10: `p_write` matches the request's `sys_write` throughout the transfer. `p_enable` is high only during the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | Peripheral clock ratio select (divisor 2^div_sel, capped at 16) |
| en_we | input | 1 | Load strobe for the slot enable mask |
| en_wdata | input | 64 | New slot enable mask |
| sys_valid | input | 1 | Request valid; held until sys_ready |
| sys_ready | output | 1 | One-cycle completion pulse |
| sys_write | input | 1 | 1 = write, 0 = read |
| sys_size | input | 2 | 00 byte, 01 halfword, 1x word |
| sys_addr | input | 16 | Byte address within the bridge window |
| sys_wdata | input | 32 | Write data in its natural lanes |
| sys_rdata | output | 32 | Read data, valid with sys_ready |
| p_tick | output | 1 | Peripheral clock strobe |
| p_sel | output | 64 | One-hot peripheral select |
| p_enable | output | 1 | Access phase indicator |
| p_write | output | 1 | Peripheral transfer direction |
| p_addr | output | 16 | Word-aligned peripheral address |
| p_wdata | output | 32 | Widened write data |
| p_rdata | input | 32 | Peripheral read data |
| p_ready | input | 1 | Peripheral ready; low adds wait states |

## Verification
The hardest situation to reach is a request that arrives when the divided strobe is not due. That request has to sit in idle while the ratio is high. Wait states from `p_ready` then stretch it, and they must land on the strobe and not between strobes. The stimulus reaches this by raising the divisor to 4 and to 16 partway through the run, with the free-running counter at an arbitrary phase. The bench peripheral holds `p_ready` low for a programmed number of access cycles, so completion falls both on and off strobe boundaries. Disabled-slot requests are interleaved with enable-mask rewrites, which makes the completion path without a select happen right after a mask change.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } pb_state_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
endpackage

// File: rtl/pb_clkdiv.sv
module pb_clkdiv #(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] div_sel,
  output logic       tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CW; i++) begin
      if (int'(div_sel) > i) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick = ((cnt & mask) == mask);
endmodule

// File: rtl/pb_lane_widen.sv
module pb_lane_widen
  import pb_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  lane,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  assign byte_v = din[8*lane +: 8];
  assign half_v = lane[1] ? din[31:16] : din[15:0];

  always_comb begin
    case (size)
      SZ_BYTE: dout = {4{byte_v}};
      SZ_HALF: dout = {2{half_v}};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/pb_slot_decode.sv
module pb_slot_decode #(
  parameter int NSLOT    = 64,
  parameter int SLOT_LSB = 10,
  localparam int SW      = $clog2(NSLOT),
  localparam int AW      = SLOT_LSB + SW
) (
  input  logic [AW-1:0]    addr,
  input  logic             active,
  output logic [NSLOT-1:0] sel
);
  logic [SW-1:0] slot;
  assign slot = addr[SLOT_LSB +: SW];

  for (genvar g = 0; g < NSLOT; g++) begin : g_sel
    assign sel[g] = active && (slot == SW'(g));
  end
endmodule

// File: rtl/periph_bridge.sv
module periph_bridge
  import pb_pkg::*;
#(
  parameter int               NSLOT    = 64,
  parameter int               SLOT_LSB = 10,
  parameter int               DIV_W    = 4,
  parameter logic [NSLOT-1:0] KEEP_ON  = NSLOT'(3),
  localparam int              SW       = $clog2(NSLOT),
  localparam int              AW       = SLOT_LSB + SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       div_sel,
  input  logic             en_we,
  input  logic [NSLOT-1:0] en_wdata,
  input  logic             sys_valid,
  output logic             sys_ready,
  input  logic             sys_write,
  input  logic [1:0]       sys_size,
  input  logic [AW-1:0]    sys_addr,
  input  logic [31:0]      sys_wdata,
  output logic [31:0]      sys_rdata,
  output logic             p_tick,
  output logic [NSLOT-1:0] p_sel,
  output logic             p_enable,
  output logic             p_write,
  output logic [AW-1:0]    p_addr,
  output logic [31:0]      p_wdata,
  input  logic [31:0]      p_rdata,
  input  logic             p_ready
);
  pb_state_e        st;
  logic [NSLOT-1:0] en_q;
  logic [AW-1:0]    addr_q;
  logic [31:0]      wdata_q;
  logic [1:0]       size_q;
  logic             wr_q;
  logic [31:0]      rdata_q;
  logic             tick;
  logic             slot_on;
  logic             in_xfer;

  pb_clkdiv #(.CW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick)
  );

  assign slot_on = en_q[sys_addr[SLOT_LSB +: SW]];
  assign in_xfer = (st == ST_SETUP) || (st == ST_ACCESS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      en_q    <= KEEP_ON;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      case (st)
        ST_IDLE: begin
          if (sys_valid && tick) begin
            addr_q  <= sys_addr;
            wdata_q <= sys_wdata;
            size_q  <= sys_size;
            wr_q    <= sys_write;
            if (slot_on) begin
              st <= ST_SETUP;
            end else begin
              st      <= ST_DONE;
              rdata_q <= '0;
            end
          end
        end
        ST_SETUP: if (tick) st <= ST_ACCESS;
        ST_ACCESS: begin
          if (tick && p_ready) begin
            st      <= ST_DONE;
            rdata_q <= wr_q ? 32'd0 : p_rdata;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  pb_slot_decode #(.NSLOT(NSLOT), .SLOT_LSB(SLOT_LSB)) u_dec (
    .addr(addr_q), .active(in_xfer), .sel(p_sel)
  );

  pb_lane_widen u_widen (
    .size(size_q), .lane(addr_q[1:0]), .din(wdata_q), .dout(p_wdata)
  );

  assign p_tick    = tick;
  assign p_enable  = (st == ST_ACCESS);
  assign p_write   = wr_q;
  assign p_addr    = {addr_q[AW-1:2], 2'b00};
  assign sys_ready = (st == ST_DONE);
  assign sys_rdata = rdata_q;
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int NSLOT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       div_sel,
  input logic             sys_ready,
  input logic [31:0]      sys_rdata,
  input logic             p_tick,
  input logic [NSLOT-1:0] p_sel,
  input logic             p_enable,
  input logic [31:0]      p_wdata,
  input logic             p_ready
);
  assert_tick_full_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == 3'd0) |-> p_tick);

  assert_sel_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|p_sel) |-> $past(p_tick));

  assert_enable_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_enable) |-> $past(p_tick));

  assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_enable && !(p_tick && p_ready)) |=> p_enable);

  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ready |=> !sys_ready);

  assert_done_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ready && $past(p_enable)) |-> $past(p_ready && p_tick));

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_sel));

  assert_blocked_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ready && !$past(p_enable)) |-> (sys_rdata == 32'd0));

  assert_enable_has_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    p_enable |-> (p_sel != '0));

  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    p_enable |-> $stable(p_wdata));
endmodule

bind periph_bridge pb_checker #(.NSLOT(NSLOT)) u_pb_chk (
  .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .sys_ready(sys_ready),
  .sys_rdata(sys_rdata), .p_tick(p_tick), .p_sel(p_sel), .p_enable(p_enable),
  .p_wdata(p_wdata), .p_ready(p_ready)
);

// File: tb/sim_periph_bridge.sv
`timescale 1ns/1ps
module sim_periph_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic        en_we = 1'b0;
  logic [63:0] en_wdata = '0;
  logic        sys_valid = 1'b0;
  logic        sys_ready;
  logic        sys_write = 1'b0;
  logic [1:0]  sys_size = 2'b10;
  logic [15:0] sys_addr = '0;
  logic [31:0] sys_wdata = '0;
  logic [31:0] sys_rdata;
  logic        p_tick;
  logic [63:0] p_sel;
  logic        p_enable;
  logic        p_write;
  logic [15:0] p_addr;
  logic [31:0] p_wdata;
  logic [31:0] p_rdata = '0;
  logic        p_ready = 1'b1;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int stall_left = 0;
  int stall_set = 0;
  bit done = 0;

  always #4 clk = ~clk;

  periph_bridge u0 (.*);

  // Reference model state
  int          m_st = 0;
  int          m_cnt = 0;
  logic [63:0] m_en = 64'h3;
  logic [15:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [1:0]  m_size = '0;
  logic        m_wr = 1'b0;
  logic [31:0] m_rd = '0;

  function automatic int mask_of(input logic [2:0] s);
    int d = (s >= 3'd4) ? 4 : int'(s);
    return (1 << d) - 1;
  endfunction

  function automatic logic [31:0] widen(input logic [1:0] sz, input logic [1:0] ln,
                                        input logic [31:0] d);
    logic [7:0] b;
    b = d >> (8 * ln);
    if (sz == 2'b00) return {b, b, b, b};
    if (sz == 2'b01) return ln[1] ? {d[31:16], d[31:16]} : {d[15:0], d[15:0]};
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_en = 64'h3;
      m_addr = '0; m_wdata = '0; m_size = '0; m_wr = 0; m_rd = '0;
    end else begin
      bit tk;
      tk = ((m_cnt & mask_of(div_sel)) == mask_of(div_sel));
      case (m_st)
        0: if (sys_valid && tk) begin
             m_addr = sys_addr; m_wdata = sys_wdata; m_size = sys_size; m_wr = sys_write;
             if (m_en[sys_addr[15:10]]) m_st = 1;
             else begin m_st = 3; m_rd = '0; end
           end
        1: if (tk) m_st = 2;
        2: if (tk && p_ready) begin m_st = 3; m_rd = m_wr ? 32'd0 : p_rdata; end
        default: m_st = 0;
      endcase
      if (en_we) m_en = en_wdata;
      m_cnt = (m_cnt + 1) & 15;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n && !done) begin
      logic [63:0] esel;
      vectors++;
      esel = (m_st == 1 || m_st == 2) ? (64'd1 << m_addr[15:10]) : 64'd0;
      chk("R1 p_tick", 64'(p_tick), 64'(((m_cnt & mask_of(div_sel)) == mask_of(div_sel))));
      chk("R2/R7/R9 p_sel", p_sel, esel);
      chk("R3/R10 p_enable", 64'(p_enable), 64'(m_st == 2));
      chk("R4/R9 sys_ready", 64'(sys_ready), 64'(m_st == 3));
      chk("R5/R9 sys_rdata", 64'(sys_rdata), 64'(m_rd));
      chk("R6 p_wdata", 64'(p_wdata), 64'(widen(m_size, m_addr[1:0], m_wdata)));
      chk("R7 p_addr", 64'(p_addr), 64'({m_addr[15:2], 2'b00}));
      chk("R10 p_write", 64'(p_write), 64'(m_wr));
    end
  end

  // Bench peripheral: programmed wait states, address-derived read data
  always @(negedge clk) begin
    if (!p_enable) stall_left = stall_set;
    else if (stall_left > 0) stall_left--;
    p_ready = (stall_left == 0) || !p_enable;
    p_rdata = 32'hBEEF0000 ^ {16'h0, p_addr} ^ {p_addr, 16'h0};
  end

  task automatic xfer(input bit wr, input logic [1:0] sz, input logic [15:0] a,
                      input logic [31:0] d, input int stalls);
    @(negedge clk);
    stall_set = stalls;
    sys_valid = 1'b1; sys_write = wr; sys_size = sz; sys_addr = a; sys_wdata = d;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #3;
      if (sys_ready) break;
    end
    @(negedge clk);
    sys_valid = 1'b0;
  endtask

  task automatic load_mask(input logic [63:0] m);
    @(negedge clk);
    en_we = 1'b1; en_wdata = m;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // Reset state (R4, R7, R10)
    vectors++;
    chk("R7 reset p_sel", p_sel, 64'd0);
    chk("R10 reset p_enable", 64'(p_enable), 64'd0);
    chk("R4 reset sys_ready", 64'(sys_ready), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // Full-rate transfers to the slots enabled at reset (R8)
    xfer(1, 2'b10, 16'h0010, 32'h11223344, 0);
    xfer(0, 2'b10, 16'h0404, 32'h0, 2);               // R3 wait states, R5 read
    // Divide by 4, narrow writes (R6)
    div_sel = 3'd2;
    xfer(1, 2'b00, 16'h0003, 32'h12345678, 0);
    xfer(1, 2'b01, 16'h0402, 32'hABCD0000, 1);
    xfer(1, 2'b00, 16'h0001, 32'h0000A500, 3);
    // Slot 5 is disabled after reset (R8, R9)
    xfer(0, 2'b10, 16'h1400, 32'h0, 0);
    xfer(1, 2'b10, 16'h1408, 32'hFFFFFFFF, 0);
    // Enable everything, divide by 16 (R1, R3)
    load_mask('1);
    div_sel = 3'd4;
    xfer(0, 2'b10, 16'h1400, 32'h0, 3);
    div_sel = 3'd7;
    xfer(1, 2'b00, 16'h1401, 32'h00C30000, 0);
    // Disable slot 1 only (R8, R9)
    load_mask(~64'h2);
    xfer(0, 2'b10, 16'h0408, 32'h0, 0);
    // Highest slot, divide by 2 (R7)
    div_sel = 3'd1;
    xfer(0, 2'b11, 16'hFC08, 32'h0, 1);
    div_sel = 3'd3;
    for (int i = 0; i < 12; i++) begin
      xfer(i[0], 2'(i % 3), 16'((i * 16'h0C04) ^ 16'h0002), 32'h9E3779B9 * (i + 1), i % 4);
      if (i == 6) div_sel = 3'd0;
    end
    repeat (4) @(posedge clk);
    #3;
    finish_run();
  end
endmodule